// File: doc/BRIEF.md
# Timer Channel Capture, Compare and PWM Unit

This block is one channel of a 16-bit timer. It does not own a counter. A shared free-running counter outside the block supplies the count value, the current count direction and a one-cycle wrap marker. The channel then works in one of four ways:

- it records the count when an input pin changes;
- it acts on an output pin when the count equals a stored value;
- it produces an edge-aligned PWM waveform;
- it produces a center-aligned PWM waveform.

A 2-bit mode field and a 2-bit edge/level field, both held in the channel's status register, choose the behaviour. A timer-wide center-aligned input works with them. Whenever a capture or a compare match occurs, the channel sets an event flag.

Software reaches the channel through a small 8-bit register port. The 16-bit channel value is split across two byte addresses. In capture mode, the first byte read freezes a copy of the whole value. The other byte, read later, therefore belongs to the same capture even if a new capture has happened in between. In the compare and PWM modes, a written byte is held in a staging register. The value used for matching changes only once both bytes have arrived, so a comparison never sees half of an update.

Top module: `tmr_chan`

## Requirements
- R1: After reset, the channel value is 0, the flag is 0, mode and edge/level are 00, and both pin_out and pin_oe are 0.
- R2: Register map. Address 0 is the status register: bit 7 is the flag, bits 6:4 read 0, bits 3:2 hold the mode and bits 1:0 hold the edge/level select. Address 1 is the value high byte and address 2 is the value low byte. Address 3 reads 0. bus_rdata is valid in the same cycle as bus_rd.
- R3: Capture read coherency. The capture mode is ctr_aligned=0 with mode 00. In this mode, the first read of either value byte freezes a copy of all 16 bits. Every value-byte read then returns the frozen copy until the other byte has been read, even if captures occur meanwhile.
- R4: Capture edges. In capture mode, edge/level 01 captures on a rising edge of cap_pin, 10 on a falling edge, and 11 on either edge. An edge is a change from the sample taken in the previous cycle to the current one. On an edge, cnt_val from that cycle is loaded into the value and the flag is set one cycle later.
- R5: Output compare. With ctr_aligned=0 and mode 01, a match of cnt_val with the value changes the pin one cycle later. Edge/level 01 toggles it, 10 drives it to 0 and 11 drives it to 1. Without a match, the pin holds.
- R6: Edge-aligned PWM. With ctr_aligned=0 and mode 1x, edge/level 10 is high-true: the pin goes to 0 on a match and to 1 on cnt_wrap. Edge/level 01 or 11 is low-true: the pin goes to 1 on a match and to 0 on cnt_wrap. When a match and a wrap fall in the same cycle, the match wins.
- R7: Center-aligned PWM. With ctr_aligned=1, edge/level 10 drives the pin to 0 on a match while cnt_up=1 and to 1 on a match while cnt_up=0. Edge/level 01 or 11 does the opposite.
- R8: Edge/level 00 disconnects the pin: pin_oe=0, pin_out=0 and no capture occurs. A compare match still sets the flag in the compare and PWM modes. Capture mode never enables the pin.
- R9: Flag clearing. Every capture or compare match sets the flag. Reading the status register while the flag is 1 arms clearing. The next write to the status register with bit 7 at 0 then clears the flag. A write that was not armed leaves the flag at 1. A set in the same cycle as a clear wins.
- R10: In the compare and PWM modes, a write to one value byte does not change the active value. The value changes only once the other byte has also been written, in either order. In capture mode, value-byte writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Shared counter value |
| cnt_up | input | 1 | 1 while the counter counts up |
| cnt_wrap | input | 1 | 1 in the cycle the counter has wrapped to 0 |
| ctr_aligned | input | 1 | Timer-wide center-aligned select |
| cap_pin | input | 1 | Synchronous capture input |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pin_out | output | 1 | Channel output level |
| pin_oe | output | 1 | Channel output enable |
| evt_flag | output | 1 | Channel event flag |

## Verification
Some properties are checked on every cycle by the assertions:
- a capture loads the counter value seen in its cycle;
- any event sets the flag;
- a single-byte write leaves the active value alone;
- an output-compare pin holds when there is no match;
- a high-true PWM match drives the pin low.

Other behaviour can only be shown by the bench's scenarios, against a behavioural model compared every clock:
- the frozen byte pair surviving a capture between the two reads;
- the read-then-write order that clears the flag;
- the precedence of a match over a wrap at value 0;
- full PWM waveforms in both alignments;
- the disconnected pin that still raises flags.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [1:0] {
    CK_CAP  = 2'd0,
    CK_OC   = 2'd1,
    CK_EPWM = 2'd2,
    CK_CPWM = 2'd3
  } chan_kind_e;

  localparam logic [1:0] ADR_STAT = 2'd0;
  localparam logic [1:0] ADR_VHI  = 2'd1;
  localparam logic [1:0] ADR_VLO  = 2'd2;

  localparam int ST_FLAG_BIT = 7;
  localparam int ST_MODE_LSB = 2;
  localparam int ST_EDGE_LSB = 0;

  localparam logic [1:0] EL_OFF  = 2'b00;
  localparam logic [1:0] EL_TGL  = 2'b01;
  localparam logic [1:0] EL_CLR  = 2'b10;
  localparam logic [1:0] EL_SET  = 2'b11;

  function automatic chan_kind_e decode_kind(input logic center, input logic [1:0] mode);
    chan_kind_e k;
    if (center)              k = CK_CPWM;
    else if (mode == 2'b00)  k = CK_CAP;
    else if (mode == 2'b01)  k = CK_OC;
    else                     k = CK_EPWM;
    return k;
  endfunction

endpackage

// File: rtl/tmr_chan_cap.sv
module tmr_chan_cap
  import tmr_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [1:0] edge_sel,
  input  logic       pin,
  output logic       cap_ev
);

  logic prev_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin;
  end

  always_comb begin
    rise   = pin & ~prev_q;
    fall   = ~pin & prev_q;
    cap_ev = enable & ((edge_sel[0] & rise) | (edge_sel[1] & fall));
  end

endmodule

// File: rtl/tmr_chan_cmp.sv
module tmr_chan_cmp
  import tmr_chan_pkg::*;
#(
  parameter int VAL_W = 16
)
(
  input  logic             clk,
  input  logic             rst_n,
  input  chan_kind_e       kind,
  input  logic [1:0]       edge_sel,
  input  logic [VAL_W-1:0] cnt_val,
  input  logic             cnt_up,
  input  logic             cnt_wrap,
  input  logic [VAL_W-1:0] cmp_val,
  output logic             cmp_ev,
  output logic             pin_q
);

  logic match;
  logic pin_d;
  logic hi_true;

  always_comb begin
    match   = (kind != CK_CAP) && (cnt_val == cmp_val);
    hi_true = (edge_sel == EL_CLR);
    cmp_ev  = match;
    pin_d   = pin_q;
    if (edge_sel != EL_OFF) begin
      unique case (kind)
        CK_OC: begin
          if (match) begin
            if (edge_sel == EL_TGL) pin_d = ~pin_q;
            else                    pin_d = (edge_sel == EL_SET);
          end
        end
        CK_EPWM: begin
          if (match)         pin_d = ~hi_true;
          else if (cnt_wrap) pin_d = hi_true;
        end
        CK_CPWM: begin
          if (match) pin_d = cnt_up ? ~hi_true : hi_true;
        end
        default: pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assert_oc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_OC && cnt_val != cmp_val) |=> $stable(pin_q));

  assert_epwm_hitrue_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_EPWM && edge_sel == 2'b10 && cnt_val == cmp_val) |=> !pin_q);

  assert_cpwm_up_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_CPWM && edge_sel == 2'b10 && cnt_up && cnt_val == cmp_val) |=> !pin_q);

endmodule

// File: rtl/tmr_chan_regif.sv
module tmr_chan_regif
  import tmr_chan_pkg::*;
#(
  parameter int BUS_W = 8
)
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  chan_kind_e         kind,
  input  logic               cap_ev,
  input  logic               cmp_ev,
  input  logic [2*BUS_W-1:0] cnt_val,
  output logic [1:0]         mode_o,
  output logic [1:0]         edge_o,
  output logic [2*BUS_W-1:0] val_o,
  output logic               flag_o
);

  localparam int VAL_W = 2 * BUS_W;

  logic [1:0]       mode_q, mode_d;
  logic [1:0]       edge_q, edge_d;
  logic             flag_q, flag_d;
  logic             arm_q, arm_d;
  logic [VAL_W-1:0] val_q, val_d;
  logic [VAL_W-1:0] stg_q, stg_d;
  logic             got_hi_q, got_hi_d;
  logic             got_lo_q, got_lo_d;
  logic             lock_q, lock_d;
  logic             first_hi_q, first_hi_d;
  logic [VAL_W-1:0] frz_q, frz_d;

  logic wr_st, wr_hi, wr_lo, rd_st, rd_hi, rd_lo, is_cap;
  logic [VAL_W-1:0] rd_src;
  logic [BUS_W-1:0] stat;

  always_comb begin
    wr_st  = bus_wr && (bus_addr == ADR_STAT);
    wr_hi  = bus_wr && (bus_addr == ADR_VHI);
    wr_lo  = bus_wr && (bus_addr == ADR_VLO);
    rd_st  = bus_rd && (bus_addr == ADR_STAT);
    rd_hi  = bus_rd && (bus_addr == ADR_VHI);
    rd_lo  = bus_rd && (bus_addr == ADR_VLO);
    is_cap = (kind == CK_CAP);
  end

  always_comb begin
    mode_d     = mode_q;
    edge_d     = edge_q;
    flag_d     = flag_q;
    arm_d      = arm_q;
    val_d      = val_q;
    stg_d      = stg_q;
    got_hi_d   = got_hi_q;
    got_lo_d   = got_lo_q;
    lock_d     = lock_q;
    first_hi_d = first_hi_q;
    frz_d      = frz_q;

    if (wr_st) begin
      mode_d = bus_wdata[ST_MODE_LSB +: 2];
      edge_d = bus_wdata[ST_EDGE_LSB +: 2];
      arm_d  = 1'b0;
      if (!bus_wdata[ST_FLAG_BIT] && arm_q) flag_d = 1'b0;
    end else if (rd_st && flag_q) begin
      arm_d = 1'b1;
    end
    if (cap_ev || cmp_ev) flag_d = 1'b1;

    if (!is_cap && wr_hi) begin
      stg_d[VAL_W-1:BUS_W] = bus_wdata;
      if (got_lo_q) begin
        val_d    = {bus_wdata, stg_q[BUS_W-1:0]};
        got_hi_d = 1'b0;
        got_lo_d = 1'b0;
      end else begin
        got_hi_d = 1'b1;
      end
    end
    if (!is_cap && wr_lo) begin
      stg_d[BUS_W-1:0] = bus_wdata;
      if (got_hi_q) begin
        val_d    = {stg_q[VAL_W-1:BUS_W], bus_wdata};
        got_hi_d = 1'b0;
        got_lo_d = 1'b0;
      end else begin
        got_lo_d = 1'b1;
      end
    end
    if (cap_ev) val_d = cnt_val;

    if (!is_cap) begin
      lock_d = 1'b0;
    end else if (rd_hi || rd_lo) begin
      if (!lock_q) begin
        lock_d     = 1'b1;
        first_hi_d = rd_hi;
        frz_d      = val_q;
      end else if (rd_hi != first_hi_q) begin
        lock_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      edge_q     <= '0;
      flag_q     <= 1'b0;
      arm_q      <= 1'b0;
      val_q      <= '0;
      stg_q      <= '0;
      got_hi_q   <= 1'b0;
      got_lo_q   <= 1'b0;
      lock_q     <= 1'b0;
      first_hi_q <= 1'b0;
      frz_q      <= '0;
    end else begin
      mode_q     <= mode_d;
      edge_q     <= edge_d;
      flag_q     <= flag_d;
      arm_q      <= arm_d;
      val_q      <= val_d;
      stg_q      <= stg_d;
      got_hi_q   <= got_hi_d;
      got_lo_q   <= got_lo_d;
      lock_q     <= lock_d;
      first_hi_q <= first_hi_d;
      frz_q      <= frz_d;
    end
  end

  always_comb begin
    rd_src = (is_cap && lock_q) ? frz_q : val_q;
    stat   = '0;
    stat[ST_FLAG_BIT]        = flag_q;
    stat[ST_MODE_LSB +: 2]   = mode_q;
    stat[ST_EDGE_LSB +: 2]   = edge_q;
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        ADR_STAT: bus_rdata = stat;
        ADR_VHI:  bus_rdata = rd_src[VAL_W-1:BUS_W];
        ADR_VLO:  bus_rdata = rd_src[BUS_W-1:0];
        default:  bus_rdata = '0;
      endcase
    end
    mode_o = mode_q;
    edge_o = edge_q;
    val_o  = val_q;
    flag_o = flag_q;
  end

  assert_capture_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (val_q == $past(cnt_val)));

  assert_event_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ev || cmp_ev) |=> flag_q);

  assert_half_write_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !got_lo_q && !cap_ev) |=> $stable(val_q));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int BUS_W = 8
)
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*BUS_W-1:0] cnt_val,
  input  logic               cnt_up,
  input  logic               cnt_wrap,
  input  logic               ctr_aligned,
  input  logic               cap_pin,
  input  logic [1:0]         bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               pin_out,
  output logic               pin_oe,
  output logic               evt_flag
);

  localparam int VAL_W = 2 * BUS_W;

  logic [1:0]       mode_w;
  logic [1:0]       edge_w;
  logic [VAL_W-1:0] val_w;
  logic             cap_ev;
  logic             cmp_ev;
  logic             pin_q;
  chan_kind_e       kind;

  always_comb begin
    kind    = decode_kind(ctr_aligned, mode_w);
    pin_oe  = (edge_w != EL_OFF) && (kind != CK_CAP);
    pin_out = pin_oe & pin_q;
  end

  tmr_chan_regif #(.BUS_W(BUS_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .kind      (kind),
    .cap_ev    (cap_ev),
    .cmp_ev    (cmp_ev),
    .cnt_val   (cnt_val),
    .mode_o    (mode_w),
    .edge_o    (edge_w),
    .val_o     (val_w),
    .flag_o    (evt_flag)
  );

  tmr_chan_cap u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (kind == CK_CAP),
    .edge_sel (edge_w),
    .pin      (cap_pin),
    .cap_ev   (cap_ev)
  );

  tmr_chan_cmp #(.VAL_W(VAL_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (kind),
    .edge_sel (edge_w),
    .cnt_val  (cnt_val),
    .cnt_up   (cnt_up),
    .cnt_wrap (cnt_wrap),
    .cmp_val  (val_w),
    .cmp_ev   (cmp_ev),
    .pin_q    (pin_q)
  );

  assert_off_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_w == 2'b00) |-> (!pin_oe && !pin_out));

endmodule

// File: tb/tmr_chan_bench.sv
module tmr_chan_bench;

  localparam int CLK_P = 10;
  localparam int MODV  = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_val = '0;
  logic        cnt_up = 1'b1;
  logic        cnt_wrap = 1'b0;
  logic        ctr_aligned = 1'b0;
  logic        cap_pin = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        pin_out, pin_oe, evt_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic        cnt_run = 1'b0;
  logic        cnt_ctr = 1'b0;
  logic [15:0] cnt_set = '0;

  // behavioural model state
  logic [15:0] m_val, m_stg;
  logic        m_flag, m_arm, m_pin, m_prev, m_ghi, m_glo;
  logic [1:0]  m_mode, m_edge;

  tmr_chan u_tmr_chan (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_up(cnt_up), .cnt_wrap(cnt_wrap),
    .ctr_aligned(ctr_aligned), .cap_pin(cap_pin), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .evt_flag(evt_flag)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int kind_of(input logic center, input logic [1:0] mode);
    if (center) return 3;
    if (mode == 2'b00) return 0;
    if (mode == 2'b01) return 1;
    return 2;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // counter source
  always @(negedge clk) begin
    if (cnt_run) begin
      if (!cnt_ctr) begin
        cnt_up = 1'b1;
        if (cnt_val >= 16'(MODV)) begin cnt_val = '0; cnt_wrap = 1'b1; end
        else begin cnt_val = cnt_val + 16'd1; cnt_wrap = 1'b0; end
      end else begin
        cnt_wrap = 1'b0;
        if (cnt_up) begin
          if (cnt_val >= 16'(MODV)) begin cnt_up = 1'b0; cnt_val = cnt_val - 16'd1; end
          else cnt_val = cnt_val + 16'd1;
        end else begin
          if (cnt_val == 16'd0) begin cnt_up = 1'b1; cnt_val = 16'd1; end
          else cnt_val = cnt_val - 16'd1;
        end
      end
    end else begin
      cnt_val  = cnt_set;
      cnt_wrap = 1'b0;
    end
  end

  // reference model, compared every clock
  always @(posedge clk) begin
    int k;
    int k2;
    bit ev;
    logic [15:0] nval;
    logic npin, nflag, narm;
    if (!rst_n) begin
      m_val = '0; m_stg = '0; m_flag = 0; m_arm = 0; m_pin = 0; m_prev = 0;
      m_ghi = 0; m_glo = 0; m_mode = '0; m_edge = '0;
    end else begin
      k = kind_of(ctr_aligned, m_mode);
      ev = 0; nval = m_val; npin = m_pin;
      if (k == 0) begin
        if ((m_edge[0] && cap_pin && !m_prev) || (m_edge[1] && !cap_pin && m_prev)) begin
          ev = 1; nval = cnt_val;
        end
      end else if (cnt_val == m_val) begin
        ev = 1;
        if (m_edge != 2'b00) begin
          if (k == 1) npin = (m_edge == 2'b01) ? !m_pin : (m_edge == 2'b11);
          else if (k == 2) npin = (m_edge != 2'b10);
          else npin = cnt_up ? (m_edge != 2'b10) : (m_edge == 2'b10);
        end
      end else if (k == 2 && cnt_wrap && m_edge != 2'b00) begin
        npin = (m_edge == 2'b10);
      end
      nflag = m_flag; narm = m_arm;
      if (bus_wr && bus_addr == 2'd0) begin
        narm = 0;
        if (!bus_wdata[7] && m_arm) nflag = 0;
      end else if (bus_rd && bus_addr == 2'd0 && m_flag) narm = 1;
      if (ev) nflag = 1;
      if (bus_wr && k != 0 && bus_addr == 2'd1) begin
        if (m_glo) begin nval = {bus_wdata, m_stg[7:0]}; m_glo = 0; m_ghi = 0; end
        else m_ghi = 1;
        m_stg[15:8] = bus_wdata;
      end
      if (bus_wr && k != 0 && bus_addr == 2'd2) begin
        if (m_ghi) begin nval = {m_stg[15:8], bus_wdata}; m_glo = 0; m_ghi = 0; end
        else m_glo = 1;
        m_stg[7:0] = bus_wdata;
      end
      if (bus_wr && bus_addr == 2'd0) begin m_mode = bus_wdata[3:2]; m_edge = bus_wdata[1:0]; end
      m_val = nval; m_pin = npin; m_flag = nflag; m_arm = narm; m_prev = cap_pin;
    end
    #2;
    k2 = kind_of(ctr_aligned, m_mode);
    check("R5,R6,R7,R8 pin_oe", int'(pin_oe), int'(m_edge != 2'b00 && k2 != 0));
    check("R5,R6,R7,R8 pin_out", int'(pin_out), int'((m_edge != 2'b00 && k2 != 0) ? m_pin : 1'b0));
    check("R4,R9 evt_flag", int'(evt_flag), int'(m_flag));
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] got);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 got = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] snap;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state, R2 map
    rd(2'd0, b); check("R1 status after reset", b, 0);
    rd(2'd1, b); check("R1 value high after reset", b, 0);
    rd(2'd2, b); check("R1 value low after reset", b, 0);
    check("R1 pin_oe after reset", pin_oe, 0);
    check("R1 flag after reset", evt_flag, 0);
    rd(2'd3, b); check("R2 address 3 reads zero", b, 0);

    // R4 capture on rising edge
    cnt_set = 16'hA55A;
    wr(2'd0, 8'h01);
    rd(2'd0, b); check("R2 status fields", b, 8'h01);
    @(negedge clk) cap_pin = 1'b1;
    idle(2);
    check("R4 rising capture flag", evt_flag, 1);
    // R3 coherent read across a later capture
    rd(2'd1, b); check("R4 captured high byte", b, 8'hA5);
    snap = m_val;
    cnt_set = 16'h1234;
    @(negedge clk) cap_pin = 1'b0;   // falling, edge 01: ignored
    idle(2);
    check("R4 falling ignored under 01", m_val, 16'hA55A);
    wr(2'd0, 8'h03);
    @(negedge clk) cap_pin = 1'b1;   // rising, edge 11: captures 1234
    idle(2);
    rd(2'd2, b); check("R3 low byte from frozen copy", b, snap[7:0]);
    rd(2'd1, b); check("R3 high byte after release", b, 8'h12);
    rd(2'd2, b); check("R3 low byte pair", b, 8'h34);

    // R4 falling edge
    cnt_set = 16'hBEEF;
    wr(2'd0, 8'h02);
    @(negedge clk) cap_pin = 1'b0;
    idle(2);
    rd(2'd1, b); check("R4 falling capture high", b, 8'hBE);
    rd(2'd2, b); check("R4 falling capture low", b, 8'hEF);

    // R10 writes ignored in capture mode
    wr(2'd1, 8'h11); wr(2'd2, 8'h22);
    rd(2'd1, b); check("R10 capture write ignored high", b, 8'hBE);
    rd(2'd2, b); check("R10 capture write ignored low", b, 8'hEF);

    // R9 flag clear sequence
    wr(2'd0, 8'h02);
    check("R9 unarmed write keeps flag", evt_flag, 1);
    rd(2'd0, b); check("R9 status shows flag", b, 8'h82);
    wr(2'd0, 8'h02);
    check("R9 armed write clears flag", evt_flag, 0);

    // R5 output compare: toggle, clear, set
    cnt_set = 16'd0;
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h00); wr(2'd2, 8'h14);
    rd(2'd2, b); check("R10 value after both bytes", b, 8'h14);
    cnt_run = 1'b1;
    idle(200);
    wr(2'd1, 8'h00);
    rd(2'd2, b); check("R10 half write keeps old value", b, 8'h14);
    idle(100);
    wr(2'd2, 8'h1E);
    rd(2'd2, b); check("R10 value after second byte", b, 8'h1E);
    wr(2'd0, 8'h06); idle(100);
    wr(2'd0, 8'h07); idle(100);

    // R6 edge-aligned PWM
    wr(2'd0, 8'h0A); wr(2'd1, 8'h00); wr(2'd2, 8'h0A); idle(150);
    wr(2'd0, 8'h09); idle(150);
    wr(2'd2, 8'h00); wr(2'd1, 8'h00); idle(100);
    wr(2'd0, 8'h0A); idle(100);
    wr(2'd2, 8'h50); wr(2'd1, 8'h00); idle(100);

    // R8 disconnected pin still flags
    wr(2'd0, 8'h04); wr(2'd1, 8'h00); wr(2'd2, 8'h05);
    rd(2'd0, b); wr(2'd0, 8'h04);
    idle(60);
    check("R8 pin_oe off with edge 00", pin_oe, 0);
    check("R8 match still flags", evt_flag, 1);

    // R7 center-aligned PWM
    cnt_ctr = 1'b1;
    ctr_aligned = 1'b1;
    wr(2'd0, 8'h02); wr(2'd1, 8'h00); wr(2'd2, 8'h0A); idle(200);
    wr(2'd0, 8'h01); idle(200);
    wr(2'd0, 8'h03); idle(100);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule